// File: doc/BRIEF.md
# Inter-processor signalling flag bank

This block holds a bank of one-bit signalling flags that a sending processor raises for a receiving processor sharing the same clock. The sender never writes the flag state directly. It writes a mask to a write-only set register, and every 1 in that mask raises the matching flag. It writes a mask to a write-only clear register, and every 1 in that mask drops the matching flag. The sender sees the live state through a flag view register.

The receiver has its own bus port. It reads the same state through a status register, which has no side effects on read. It retires flags by writing ones to an acknowledge register. The lowest four flags each drive a level interrupt request toward the receiver. The other flags serve only for polling.

When a set and a clear or acknowledge hit the same bit in one cycle, the set wins, so no event is lost. Flag count, interrupt count, address width and the collision priority are parameters.

Top module: `ipc_flag_bank`

## Requirements
- R1: After reset every flag is 0. The flag view and status registers read 0, and every interrupt output is 0.
- R2: A sender write to the set register (byte address 0x0) raises each flag whose data bit is 1. Flag n is at bit n-1. Bits written as 0 leave their flags unchanged. The new state is visible from the next cycle.
- R3: A sender write to the clear register (byte address 0x4) lowers each flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R4: A receiver write to the acknowledge register (receiver byte address 0x0) lowers each flag whose data bit is 1.
- R5: When a set and an acknowledge or clear target the same bit in the same cycle, that flag ends up 1. Other acknowledged bits are still lowered.
- R6: A sender read of the set or clear register address returns all zeros.
- R7: The sender flag view (byte address 0x8) and the receiver status register (receiver byte address 0x4) return the identical 32-bit flag state.
- R8: Interrupt output i (i = 0..3) is a level equal to flag bit i. It changes only in the cycle after a register write.
- R9: Flags at bits 4..31 never drive any interrupt output.
- R10: Writes to unmapped addresses on either port change no flag. Reads of unmapped addresses, and bus outputs with no read strobe, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_addr | input | 4 | Sender byte address |
| snd_wr | input | 1 | Sender write strobe |
| snd_wdata | input | 32 | Sender write data |
| snd_rd | input | 1 | Sender read strobe |
| snd_rdata | output | 32 | Sender read data (combinational) |
| rcv_addr | input | 4 | Receiver byte address |
| rcv_wr | input | 1 | Receiver write strobe |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rd | input | 1 | Receiver read strobe |
| rcv_rdata | output | 32 | Receiver read data (combinational) |
| irq | output | 4 | Level interrupt requests, one per low flag |

## Verification
The two functions that can coincide are a sender set and a receiver acknowledge that target the same flag in one clock. The bench provokes this by driving both bus ports in the same cycle. The set mask and the acknowledge mask overlap on some bits and differ on others. The result is read back through the flag view and the status register. Overlapping bits must remain raised, and acknowledged bits that are not also being set must be lowered. A behavioural model applies the set-wins rule each clock, and the interrupt outputs are compared against it on every cycle.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;
   // sender side byte offsets
   localparam int unsigned SND_SET_OFS  = 0;
   localparam int unsigned SND_CLR_OFS  = 4;
   localparam int unsigned SND_VIEW_OFS = 8;
   // receiver side byte offsets
   localparam int unsigned RCV_ACK_OFS  = 0;
   localparam int unsigned RCV_STAT_OFS = 4;
   // minimum address width able to reach every offset
   localparam int unsigned MIN_ADDR_W   = 4;

   typedef enum logic [1:0] {
      SREG_NONE = 2'd0,
      SREG_SET  = 2'd1,
      SREG_CLR  = 2'd2,
      SREG_VIEW = 2'd3
   } snd_reg_e;
endpackage

// File: rtl/ipc_wr_decode.sv
module ipc_wr_decode
   import ipc_flag_pkg::*;
#(
   parameter int unsigned NFLAGS = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] snd_addr,
   input  logic              snd_wr,
   input  logic [NFLAGS-1:0] snd_wdata,
   input  logic [ADDR_W-1:0] rcv_addr,
   input  logic              rcv_wr,
   input  logic [NFLAGS-1:0] rcv_wdata,
   output logic [NFLAGS-1:0] set_mask,
   output logic [NFLAGS-1:0] clr_mask
);
   snd_reg_e sel;
   logic     ack_hit;

   always_comb begin
      sel = SREG_NONE;
      if (snd_addr == ADDR_W'(SND_SET_OFS))       sel = SREG_SET;
      else if (snd_addr == ADDR_W'(SND_CLR_OFS))  sel = SREG_CLR;
      else if (snd_addr == ADDR_W'(SND_VIEW_OFS)) sel = SREG_VIEW;
   end

   assign ack_hit  = rcv_wr && (rcv_addr == ADDR_W'(RCV_ACK_OFS));
   assign set_mask = (snd_wr && sel == SREG_SET) ? snd_wdata : '0;
   assign clr_mask = ((snd_wr && sel == SREG_CLR) ? snd_wdata : '0)
                   | (ack_hit ? rcv_wdata : '0);
endmodule

// File: rtl/ipc_flag_cell.sv
module ipc_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   logic d;

   generate
      if (SET_WINS) begin : g_set_first
         assign d = set_i | (q & ~clr_i);
      end else begin : g_clr_first
         assign d = (q | set_i) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end
endmodule

// File: rtl/ipc_read_mux.sv
module ipc_read_mux
   import ipc_flag_pkg::*;
#(
   parameter int unsigned NFLAGS = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] snd_addr,
   input  logic              snd_rd,
   input  logic [ADDR_W-1:0] rcv_addr,
   input  logic              rcv_rd,
   input  logic [NFLAGS-1:0] flags,
   output logic [NFLAGS-1:0] snd_rdata,
   output logic [NFLAGS-1:0] rcv_rdata
);
   always_comb begin
      snd_rdata = '0;
      // set and clear offsets deliberately fall through to zero
      if (snd_rd && snd_addr == ADDR_W'(SND_VIEW_OFS)) snd_rdata = flags;
   end

   always_comb begin
      rcv_rdata = '0;
      if (rcv_rd && rcv_addr == ADDR_W'(RCV_STAT_OFS)) rcv_rdata = flags;
   end
endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank
   import ipc_flag_pkg::*;
#(
   parameter int unsigned NFLAGS   = 32,
   parameter int unsigned NIRQ     = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] snd_addr,
   input  logic              snd_wr,
   input  logic [NFLAGS-1:0] snd_wdata,
   input  logic              snd_rd,
   output logic [NFLAGS-1:0] snd_rdata,
   input  logic [ADDR_W-1:0] rcv_addr,
   input  logic              rcv_wr,
   input  logic [NFLAGS-1:0] rcv_wdata,
   input  logic              rcv_rd,
   output logic [NFLAGS-1:0] rcv_rdata,
   output logic [NIRQ-1:0]   irq
);
   localparam int unsigned PLAIN_FLAGS = NFLAGS - NIRQ;

   generate
      if (NIRQ == 0 || NIRQ > NFLAGS) begin : g_bad_irq
         $error("ipc_flag_bank: NIRQ must be 1..NFLAGS");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("ipc_flag_bank: ADDR_W too narrow for register offsets");
      end
      if (NFLAGS > 32) begin : g_bad_width
         $error("ipc_flag_bank: NFLAGS limited to one bus word");
      end
   endgenerate

   logic [NFLAGS-1:0] set_mask;
   logic [NFLAGS-1:0] clr_mask;
   logic [NFLAGS-1:0] flag_q;

   ipc_wr_decode #(.NFLAGS(NFLAGS), .ADDR_W(ADDR_W)) dec_i (
      .snd_addr (snd_addr),
      .snd_wr   (snd_wr),
      .snd_wdata(snd_wdata),
      .rcv_addr (rcv_addr),
      .rcv_wr   (rcv_wr),
      .rcv_wdata(rcv_wdata),
      .set_mask (set_mask),
      .clr_mask (clr_mask)
   );

   generate
      for (genvar b = 0; b < NFLAGS; b++) begin : g_cell
         ipc_flag_cell #(.SET_WINS(SET_WINS)) cell_i (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_mask[b]),
            .clr_i(clr_mask[b]),
            .q    (flag_q[b])
         );
      end
   endgenerate

   ipc_read_mux #(.NFLAGS(NFLAGS), .ADDR_W(ADDR_W)) rmux_i (
      .snd_addr (snd_addr),
      .snd_rd   (snd_rd),
      .rcv_addr (rcv_addr),
      .rcv_rd   (rcv_rd),
      .flags    (flag_q),
      .snd_rdata(snd_rdata),
      .rcv_rdata(rcv_rdata)
   );

   // only the low flags reach the receiver as interrupts; the
   // PLAIN_FLAGS upper flags are visible solely through reads
   generate
      if (PLAIN_FLAGS >= 0) begin : g_irq
         assign irq = flag_q[NIRQ-1:0];
      end
   endgenerate
endmodule

// File: rtl/ipc_flag_bank_chk.sv
module ipc_flag_bank_chk
   import ipc_flag_pkg::*;
#(
   parameter int unsigned NFLAGS = 32,
   parameter int unsigned NIRQ   = 4,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] snd_addr,
   input logic              snd_wr,
   input logic [NFLAGS-1:0] snd_wdata,
   input logic              snd_rd,
   input logic [NFLAGS-1:0] snd_rdata,
   input logic [ADDR_W-1:0] rcv_addr,
   input logic              rcv_wr,
   input logic [NFLAGS-1:0] rcv_wdata,
   input logic              rcv_rd,
   input logic [NFLAGS-1:0] rcv_rdata,
   input logic [NIRQ-1:0]   irq,
   input logic [NFLAGS-1:0] flags
);
   logic snd_set_w, snd_clr_w, rcv_ack_w;
   assign snd_set_w = snd_wr && snd_addr == ADDR_W'(SND_SET_OFS);
   assign snd_clr_w = snd_wr && snd_addr == ADDR_W'(SND_CLR_OFS);
   assign rcv_ack_w = rcv_wr && rcv_addr == ADDR_W'(RCV_ACK_OFS);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flags == '0 && irq == '0));

   // R2
   set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_set_w |=> ((flags & $past(snd_wdata)) == $past(snd_wdata)));

   // R3
   clear_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_clr_w |=> ((flags & $past(snd_wdata)) == '0));

   // R4
   ack_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_ack_w && !snd_set_w) |=> ((flags & $past(rcv_wdata)) == '0));

   // R5
   set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_ack_w && snd_set_w) |=>
         ((flags & $past(snd_wdata)) == $past(snd_wdata) &&
          (flags & $past(rcv_wdata & ~snd_wdata)) == '0));

   // R6
   wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_rd && (snd_addr == ADDR_W'(SND_SET_OFS) ||
                  snd_addr == ADDR_W'(SND_CLR_OFS))) |-> snd_rdata == '0);

   // R7
   views_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_rd && snd_addr == ADDR_W'(SND_VIEW_OFS) &&
       rcv_rd && rcv_addr == ADDR_W'(RCV_STAT_OFS)) |-> snd_rdata == rcv_rdata);

   // R8
   irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq) |-> $past(snd_wr || rcv_wr));

   // R10
   idle_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!snd_rd && !rcv_rd) |-> (snd_rdata == '0 && rcv_rdata == '0));
endmodule

bind ipc_flag_bank ipc_flag_bank_chk #(
   .NFLAGS(NFLAGS), .NIRQ(NIRQ), .ADDR_W(ADDR_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .snd_addr (snd_addr),
   .snd_wr   (snd_wr),
   .snd_wdata(snd_wdata),
   .snd_rd   (snd_rd),
   .snd_rdata(snd_rdata),
   .rcv_addr (rcv_addr),
   .rcv_wr   (rcv_wr),
   .rcv_wdata(rcv_wdata),
   .rcv_rd   (rcv_rd),
   .rcv_rdata(rcv_rdata),
   .irq      (irq),
   .flags    (flag_q)
);

// File: tb/ipc_flag_bank_tb_top.sv
module ipc_flag_bank_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  snd_addr = '0;
   logic        snd_wr = 1'b0;
   logic [31:0] snd_wdata = '0;
   logic        snd_rd = 1'b0;
   logic [31:0] snd_rdata;
   logic [3:0]  rcv_addr = '0;
   logic        rcv_wr = 1'b0;
   logic [31:0] rcv_wdata = '0;
   logic        rcv_rd = 1'b0;
   logic [31:0] rcv_rdata;
   logic [3:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] model;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_flag_bank dut_i (
      .clk(clk), .rst_n(rst_n),
      .snd_addr(snd_addr), .snd_wr(snd_wr), .snd_wdata(snd_wdata),
      .snd_rd(snd_rd), .snd_rdata(snd_rdata),
      .rcv_addr(rcv_addr), .rcv_wr(rcv_wr), .rcv_wdata(rcv_wdata),
      .rcv_rd(rcv_rd), .rcv_rdata(rcv_rdata),
      .irq(irq)
   );

   // behavioural reference: set beats any clear or acknowledge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model <= '0;
      else begin
         logic [31:0] up, down;
         up   = (snd_wr && snd_addr == 4'h0) ? snd_wdata : 32'h0;
         down = ((snd_wr && snd_addr == 4'h4) ? snd_wdata : 32'h0)
              | ((rcv_wr && rcv_addr == 4'h0) ? rcv_wdata : 32'h0);
         model <= (model & ~down) | up;
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R8 / R9: interrupt levels follow the model on every clock
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) check("R8 irq vs model", {28'h0, irq}, {28'h0, model[3:0]});
   end

   task automatic step(logic sw, logic sr, logic [3:0] sa, logic [31:0] sd,
                       logic rw, logic rr, logic [3:0] ra, logic [31:0] rd);
      @(negedge clk);
      snd_wr = sw; snd_rd = sr; snd_addr = sa; snd_wdata = sd;
      rcv_wr = rw; rcv_rd = rr; rcv_addr = ra; rcv_wdata = rd;
      #1;
   endtask

   task automatic idle();
      step(0, 0, 4'h0, 32'h0, 0, 0, 4'h0, 32'h0);
   endtask

   task automatic read_view(string tag, logic [31:0] exp);
      step(0, 1, 4'h8, 32'h0, 0, 1, 4'h4, 32'h0);
      check(tag, snd_rdata, exp);
      check(tag, rcv_rdata, exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1
      read_view("R1 reset view", 32'h0);
      check("R1 reset irq", {28'h0, irq}, 32'h0);

      // R2 set two low flags
      step(1, 0, 4'h0, 32'h0000_0005, 0, 0, 4'h0, 32'h0);
      idle();
      read_view("R2 set", 32'h0000_0005);
      check("R8 irq level", {28'h0, irq}, 32'h5);

      // R2 zeros written to set change nothing
      step(1, 0, 4'h0, 32'h0, 0, 0, 4'h0, 32'h0);
      idle();
      read_view("R2 zero write", 32'h0000_0005);

      // R9 upper flags raise no interrupt
      step(1, 0, 4'h0, 32'hF000_0000, 0, 0, 4'h0, 32'h0);
      idle();
      read_view("R9 upper set", 32'hF000_0005);
      check("R9 irq unchanged", {28'h0, irq}, 32'h5);

      // R3 sender clear
      step(1, 0, 4'h4, 32'h1000_0004, 0, 0, 4'h0, 32'h0);
      idle();
      read_view("R3 clear", 32'hE000_0001);

      // R4 receiver acknowledge
      step(0, 0, 4'h0, 32'h0, 1, 0, 4'h0, 32'h0000_0001);
      idle();
      read_view("R4 ack", 32'hE000_0000);
      check("R4 irq low", {28'h0, irq}, 32'h0);

      // R5 set and ack collide on bit 1
      step(1, 0, 4'h0, 32'h0000_0003, 1, 0, 4'h0, 32'h2000_0002);
      idle();
      read_view("R5 set wins", 32'hC000_0003);

      // R6 write-only addresses read zero
      step(0, 1, 4'h0, 32'h0, 0, 0, 4'h0, 32'h0);
      check("R6 set addr read", snd_rdata, 32'h0);
      step(0, 1, 4'h4, 32'h0, 0, 0, 4'h0, 32'h0);
      check("R6 clr addr read", snd_rdata, 32'h0);

      // R7 both views together
      step(0, 1, 4'h8, 32'h0, 0, 1, 4'h4, 32'h0);
      check("R7 views equal", snd_rdata, rcv_rdata);

      // R10 unmapped writes and reads
      step(1, 0, 4'hC, 32'hFFFF_FFFF, 1, 0, 4'h8, 32'hFFFF_FFFF);
      idle();
      read_view("R10 unmapped write", 32'hC000_0003);
      step(0, 1, 4'hC, 32'h0, 0, 1, 4'hC, 32'h0);
      check("R10 unmapped snd read", snd_rdata, 32'h0);
      check("R10 unmapped rcv read", rcv_rdata, 32'h0);

      // R3 clear everything
      step(1, 0, 4'h4, 32'hFFFF_FFFF, 0, 0, 4'h0, 32'h0);
      idle();
      read_view("R3 clear all", 32'h0);
      check("R8 irq after clear", {28'h0, irq}, 32'h0);

      idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule